// File: doc/BRIEF.md
# Double-Buffered Command Offload Register Block

This block sits between a host core's simple memory-mapped bus and a group of streaming co-processor instances. For each instance it holds a staging set of configuration registers: base pointers for every address generator, iteration bounds for every hardware loop, a stride per address generator and loop, three loop-level settings (outermost level, accumulator init level and write-back level) and an opcode. The host fills the staging set with ordinary writes and reads it back at any time.

A write to the command offset takes a snapshot of the whole staging set, with the opcode taken from that write's data, and hands it to the execution engine with a one-cycle start pulse. The engine sees the snapshot on a dedicated output that only changes at a launch, so the host can stage the next job while the current one runs. A second command written during execution waits in a pending slot and launches when the engine signals done. A third command stalls the bus through a ready signal until the slot frees. A broadcast instance select lets one bus write reach every instance, including a broadcast launch.

Top module: `cmd_offload_hub`

## Requirements
- R1: After reset all staging and snapshot fields read zero, every instance is idle with nothing pending, no start pulse is driven and `bus_ready` is high.
- R2: The bus address is `{instance select, 6-bit word offset}`. Offset 2 holds the level settings (outer level in the lowest LVL_W bits, then init, then write-back), offsets 8+a hold base pointer a, offsets 16+l hold loop bound l, offsets 32+a*NUM_LOOPS+l hold stride (a,l); a write keeps only the field's width and a read returns it zero-extended.
- R3: A write to offset 1 (command) on an idle instance stores the opcode in the staging set, drives `eng_start` high for exactly the one cycle after the write's clock edge, and in that same cycle `eng_cfg` holds the snapshot packed from bit 0 upward as: opcode, outer, init, write-back level, bases in index order, bounds in index order, strides in index order.
- R4: Writes to staging registers while a command runs change the read-back value but leave `eng_cfg` unchanged.
- R5: Offset 0 is a read-only status word with bit 0 busy and bit 1 pending; busy stays set from launch until `eng_done` while nothing is pending, and then clears.
- R6: A command written while the instance is busy is captured as pending together with its snapshot and produces no start pulse; the done of the running command launches it, with the start pulse and that snapshot in the next cycle.
- R7: While an instance has a pending command, a further command write to it holds `bus_ready` low and is not taken; it is taken in the first cycle in which the slot is free.
- R8: Instance select all ones addresses every instance at once, for staging writes and for command writes that launch all of them.
- R9: A read with the broadcast select returns the register of instance 0.
- R10: Writes to an offset outside the map or to an instance select that is neither a present instance nor the broadcast value change nothing and start nothing; reads of them return zero.
- R11: `eng_done` on an idle instance is ignored: status and snapshot stay unchanged and no start is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | SEL_W+6 | Instance select and word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write request |
| bus_ready | output | 1 | Low while a command write must wait |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| eng_start | output | NUM_INST | One-cycle launch pulse per instance |
| eng_done | input | NUM_INST | Completion pulse per instance |
| eng_cfg | output | NUM_INST*CFG_W | Snapshot per instance, instance i at bits i*CFG_W upward |

## Verification
The bench builds the block with its defaults: two instances, two address generators and three loops, so a two-bit instance select leaves one select value (2) that is neither an instance nor the broadcast code. That spare value makes the unmapped-instance case of R10 reachable, and two instances let the broadcast and instance-0 read aliasing be told apart from per-instance state. Three loops give level fields of two bits and six strides, so masking on write and the stride indexing by generator and loop are both exercised.

// File: rtl/cmd_offload_pkg.sv
package cmd_offload_pkg;

    localparam int OFS_W = 6;

    localparam logic [OFS_W-1:0] OFS_STATUS = 6'd0;
    localparam logic [OFS_W-1:0] OFS_CMD    = 6'd1;
    localparam logic [OFS_W-1:0] OFS_LEVELS = 6'd2;
    localparam logic [OFS_W-1:0] OFS_BASE   = 6'd8;
    localparam logic [OFS_W-1:0] OFS_BOUND  = 6'd16;
    localparam logic [OFS_W-1:0] OFS_STRIDE = 6'd32;

    localparam int ST_BUSY = 0;
    localparam int ST_PEND = 1;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_STATUS,
        FLD_CMD,
        FLD_LEVELS,
        FLD_BASE,
        FLD_BOUND,
        FLD_STRIDE
    } fld_e;

    typedef struct packed {
        fld_e       kind;
        logic [4:0] idx;
    } reg_sel_t;

    function automatic reg_sel_t classify(input logic [OFS_W-1:0] ofs,
                                          input int n_agu, input int n_loop);
        reg_sel_t         r;
        logic [OFS_W-1:0] d;
        r.kind = FLD_NONE;
        r.idx  = '0;
        d      = '0;
        if (ofs == OFS_STATUS) begin
            r.kind = FLD_STATUS;
        end else if (ofs == OFS_CMD) begin
            r.kind = FLD_CMD;
        end else if (ofs == OFS_LEVELS) begin
            r.kind = FLD_LEVELS;
        end else if (ofs >= OFS_BASE && int'(ofs) < int'(OFS_BASE) + n_agu) begin
            d      = ofs - OFS_BASE;
            r.kind = FLD_BASE;
            r.idx  = d[4:0];
        end else if (ofs >= OFS_BOUND && int'(ofs) < int'(OFS_BOUND) + n_loop) begin
            d      = ofs - OFS_BOUND;
            r.kind = FLD_BOUND;
            r.idx  = d[4:0];
        end else if (ofs >= OFS_STRIDE && int'(ofs) < int'(OFS_STRIDE) + n_agu * n_loop) begin
            d      = ofs - OFS_STRIDE;
            r.kind = FLD_STRIDE;
            r.idx  = d[4:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/cmd_addr_decode.sv
module cmd_addr_decode #(
    parameter int NUM_INST = 2,
    parameter int SEL_W    = 2,
    parameter int OFS_W    = 6,
    localparam int BUS_AW  = SEL_W + OFS_W
) (
    input  logic [BUS_AW-1:0]   addr,
    output logic [OFS_W-1:0]    ofs,
    output logic [NUM_INST-1:0] wr_hit,
    output logic [NUM_INST-1:0] rd_hot
);
    logic [SEL_W-1:0] sel;
    logic             bcast;

    assign sel   = addr[BUS_AW-1:OFS_W];
    assign ofs   = addr[OFS_W-1:0];
    assign bcast = &sel;

    for (genvar i = 0; i < NUM_INST; i++) begin : g_hit
        assign wr_hit[i] = bcast || (sel == SEL_W'(i));
        if (i == 0) begin : g_zero
            assign rd_hot[i] = bcast || (sel == SEL_W'(0));
        end else begin : g_other
            assign rd_hot[i] = !bcast && (sel == SEL_W'(i));
        end
    end
endmodule

// File: rtl/cmd_stage_regs.sv
module cmd_stage_regs
    import cmd_offload_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int OPC_W     = 4,
    parameter int LVL_W     = 2,
    parameter int NUM_AGU   = 2,
    parameter int NUM_LOOPS = 3,
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 12,
    parameter int STR_W     = 12,
    parameter int CFG_W     = 150
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              pend,
    output logic [CFG_W-1:0]  stage_cfg,
    output logic [DATA_W-1:0] rdata
);
    localparam int NUM_STR   = NUM_AGU * NUM_LOOPS;
    localparam int LV_POS    = OPC_W;
    localparam int BASE_POS  = LV_POS + 3 * LVL_W;
    localparam int BOUND_POS = BASE_POS + NUM_AGU * ADDR_W;
    localparam int STR_POS   = BOUND_POS + NUM_LOOPS * CNT_W;

    logic [OPC_W-1:0]  opc_q;
    logic [LVL_W-1:0]  lvl_q    [3];
    logic [ADDR_W-1:0] base_q   [NUM_AGU];
    logic [CNT_W-1:0]  bound_q  [NUM_LOOPS];
    logic [STR_W-1:0]  stride_q [NUM_STR];
    reg_sel_t          rs;

    assign rs = classify(ofs, NUM_AGU, NUM_LOOPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            opc_q <= '0;
            for (int k = 0; k < 3; k++)         lvl_q[k]    <= '0;
            for (int k = 0; k < NUM_AGU; k++)   base_q[k]   <= '0;
            for (int k = 0; k < NUM_LOOPS; k++) bound_q[k]  <= '0;
            for (int k = 0; k < NUM_STR; k++)   stride_q[k] <= '0;
        end else if (wr_en) begin
            case (rs.kind)
                FLD_CMD: opc_q <= wdata[OPC_W-1:0];
                FLD_LEVELS: begin
                    for (int k = 0; k < 3; k++) lvl_q[k] <= wdata[k*LVL_W +: LVL_W];
                end
                FLD_BASE: begin
                    for (int k = 0; k < NUM_AGU; k++)
                        if (rs.idx == 5'(k)) base_q[k] <= wdata[ADDR_W-1:0];
                end
                FLD_BOUND: begin
                    for (int k = 0; k < NUM_LOOPS; k++)
                        if (rs.idx == 5'(k)) bound_q[k] <= wdata[CNT_W-1:0];
                end
                FLD_STRIDE: begin
                    for (int k = 0; k < NUM_STR; k++)
                        if (rs.idx == 5'(k)) stride_q[k] <= wdata[STR_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (rs.kind)
            FLD_STATUS: begin
                rdata[ST_BUSY] = busy;
                rdata[ST_PEND] = pend;
            end
            FLD_CMD:    rdata = DATA_W'(opc_q);
            FLD_LEVELS: rdata = DATA_W'({lvl_q[2], lvl_q[1], lvl_q[0]});
            FLD_BASE: begin
                for (int k = 0; k < NUM_AGU; k++)
                    if (rs.idx == 5'(k)) rdata = DATA_W'(base_q[k]);
            end
            FLD_BOUND: begin
                for (int k = 0; k < NUM_LOOPS; k++)
                    if (rs.idx == 5'(k)) rdata = DATA_W'(bound_q[k]);
            end
            FLD_STRIDE: begin
                for (int k = 0; k < NUM_STR; k++)
                    if (rs.idx == 5'(k)) rdata = DATA_W'(stride_q[k]);
            end
            default: rdata = '0;
        endcase
    end

    assign stage_cfg[OPC_W-1:0] = opc_q;
    for (genvar k = 0; k < 3; k++) begin : g_lvl
        assign stage_cfg[LV_POS + k*LVL_W +: LVL_W] = lvl_q[k];
    end
    for (genvar k = 0; k < NUM_AGU; k++) begin : g_base
        assign stage_cfg[BASE_POS + k*ADDR_W +: ADDR_W] = base_q[k];
    end
    for (genvar k = 0; k < NUM_LOOPS; k++) begin : g_bound
        assign stage_cfg[BOUND_POS + k*CNT_W +: CNT_W] = bound_q[k];
    end
    for (genvar k = 0; k < NUM_STR; k++) begin : g_str
        assign stage_cfg[STR_POS + k*STR_W +: STR_W] = stride_q[k];
    end
endmodule

// File: rtl/cmd_launch_ctrl.sv
module cmd_launch_ctrl #(
    parameter int CFG_W = 150
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [CFG_W-1:0] new_cfg,
    input  logic             done,
    output logic             busy,
    output logic             pend,
    output logic             start,
    output logic [CFG_W-1:0] active_cfg
);
    logic [CFG_W-1:0] pend_cfg;
    logic             finish;

    assign finish = busy && done;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            pend       <= 1'b0;
            start      <= 1'b0;
            active_cfg <= '0;
            pend_cfg   <= '0;
        end else begin
            start <= 1'b0;
            if (finish) begin
                if (pend) begin
                    active_cfg <= pend_cfg;
                    start      <= 1'b1;
                    pend       <= 1'b0;
                end else if (cmd_wr) begin
                    active_cfg <= new_cfg;
                    start      <= 1'b1;
                end else begin
                    busy <= 1'b0;
                end
            end else if (cmd_wr) begin
                if (!busy) begin
                    active_cfg <= new_cfg;
                    start      <= 1'b1;
                    busy       <= 1'b1;
                end else if (!pend) begin
                    pend_cfg <= new_cfg;
                    pend     <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cmd_offload_hub.sv
module cmd_offload_hub
    import cmd_offload_pkg::*;
#(
    parameter int NUM_INST  = 2,
    parameter int DATA_W    = 32,
    parameter int OPC_W     = 4,
    parameter int NUM_AGU   = 2,
    parameter int NUM_LOOPS = 3,
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 12,
    parameter int STR_W     = 12,
    localparam int SEL_W    = $clog2(NUM_INST + 1),
    localparam int BUS_AW   = SEL_W + OFS_W,
    localparam int LVL_W    = $clog2(NUM_LOOPS + 1),
    localparam int NUM_STR  = NUM_AGU * NUM_LOOPS,
    localparam int CFG_W    = OPC_W + 3 * LVL_W + NUM_AGU * ADDR_W
                            + NUM_LOOPS * CNT_W + NUM_STR * STR_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [BUS_AW-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic                      bus_we,
    output logic                      bus_ready,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NUM_INST-1:0]       eng_start,
    input  logic [NUM_INST-1:0]       eng_done,
    output logic [NUM_INST*CFG_W-1:0] eng_cfg
);
    logic [OFS_W-1:0]    ofs;
    logic [NUM_INST-1:0] wr_hit;
    logic [NUM_INST-1:0] rd_hot;
    logic [NUM_INST-1:0] busy_vec;
    logic [NUM_INST-1:0] pend_vec;
    logic [DATA_W-1:0]   rd_arr [NUM_INST];
    logic                is_cmd;
    logic                wr_go;

    cmd_addr_decode #(
        .NUM_INST (NUM_INST),
        .SEL_W    (SEL_W),
        .OFS_W    (OFS_W)
    ) u_dec (
        .addr   (bus_addr),
        .ofs    (ofs),
        .wr_hit (wr_hit),
        .rd_hot (rd_hot)
    );

    assign is_cmd    = (ofs == OFS_CMD);
    assign bus_ready = !(bus_we && is_cmd && |(wr_hit & pend_vec));
    assign wr_go     = bus_we && bus_ready;

    for (genvar i = 0; i < NUM_INST; i++) begin : g_inst
        logic [CFG_W-1:0] stage_cfg;
        logic [CFG_W-1:0] launch_cfg;
        logic             wr_en;

        assign wr_en      = wr_go && wr_hit[i];
        assign launch_cfg = {stage_cfg[CFG_W-1:OPC_W], bus_wdata[OPC_W-1:0]};

        cmd_stage_regs #(
            .DATA_W    (DATA_W),
            .OPC_W     (OPC_W),
            .LVL_W     (LVL_W),
            .NUM_AGU   (NUM_AGU),
            .NUM_LOOPS (NUM_LOOPS),
            .ADDR_W    (ADDR_W),
            .CNT_W     (CNT_W),
            .STR_W     (STR_W),
            .CFG_W     (CFG_W)
        ) u_stage (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_en),
            .ofs       (ofs),
            .wdata     (bus_wdata),
            .busy      (busy_vec[i]),
            .pend      (pend_vec[i]),
            .stage_cfg (stage_cfg),
            .rdata     (rd_arr[i])
        );

        cmd_launch_ctrl #(
            .CFG_W (CFG_W)
        ) u_launch (
            .clk        (clk),
            .rst        (rst),
            .cmd_wr     (wr_en && is_cmd),
            .new_cfg    (launch_cfg),
            .done       (eng_done[i]),
            .busy       (busy_vec[i]),
            .pend       (pend_vec[i]),
            .start      (eng_start[i]),
            .active_cfg (eng_cfg[i*CFG_W +: CFG_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_INST; i++)
            if (rd_hot[i]) bus_rdata = bus_rdata | rd_arr[i];
    end
endmodule

// File: rtl/cmd_offload_checker.sv
module cmd_offload_checker #(
    parameter int NUM_INST = 2,
    parameter int CFG_W    = 150
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_we,
    input logic                      bus_ready,
    input logic [NUM_INST-1:0]       eng_start,
    input logic [NUM_INST-1:0]       eng_done,
    input logic [NUM_INST*CFG_W-1:0] eng_cfg,
    input logic [NUM_INST-1:0]       busy_vec,
    input logic [NUM_INST-1:0]       pend_vec
);
    p_stall_only_on_write_r7: assert property (@(posedge clk) disable iff (rst)
        !bus_ready |-> bus_we);

    for (genvar i = 0; i < NUM_INST; i++) begin : g_chk
        p_cfg_moves_only_at_launch_r4: assert property (@(posedge clk) disable iff (rst)
            !$stable(eng_cfg[i*CFG_W +: CFG_W]) |-> eng_start[i]);

        p_start_while_busy_r3: assert property (@(posedge clk) disable iff (rst)
            eng_start[i] |-> busy_vec[i]);

        p_pending_implies_busy_r6: assert property (@(posedge clk) disable iff (rst)
            pend_vec[i] |-> busy_vec[i]);

        p_busy_clears_on_done_r5: assert property (@(posedge clk) disable iff (rst)
            $fell(busy_vec[i]) |-> $past(eng_done[i]));

        p_idle_done_no_start_r11: assert property (@(posedge clk) disable iff (rst)
            (!busy_vec[i] && !bus_we) |=> !eng_start[i]);
    end
endmodule

bind cmd_offload_hub cmd_offload_checker #(
    .NUM_INST (NUM_INST),
    .CFG_W    (CFG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_ready (bus_ready),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .eng_cfg   (eng_cfg),
    .busy_vec  (busy_vec),
    .pend_vec  (pend_vec)
);

// File: tb/tb_cmd_offload_hub.sv
module tb_cmd_offload_hub;
    localparam int NI = 2, DW = 32, OW = 4, NA = 2, NL = 3, AW = 16, CW = 12, SW = 12;
    localparam int LW = 2, NS = NA * NL;
    localparam int CFG = OW + 3 * LW + NA * AW + NL * CW + NS * SW;

    logic            clk = 0;
    logic            rst = 1;
    logic [7:0]      bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic            bus_we = 0;
    logic            bus_ready;
    logic [DW-1:0]   bus_rdata;
    logic [NI-1:0]   eng_start;
    logic [NI-1:0]   eng_done = '0;
    logic [NI*CFG-1:0] eng_cfg;

    int n_chk = 0;
    int n_bad = 0;

    // bench-side model of the staging registers
    logic [OW-1:0] m_opc   [NI];
    logic [LW-1:0] m_lv    [NI][3];
    logic [AW-1:0] m_base  [NI][NA];
    logic [CW-1:0] m_bound [NI][NL];
    logic [SW-1:0] m_str   [NI][NS];

    cmd_offload_hub dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_done(eng_done), .eng_cfg(eng_cfg)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] A(int sel, int ofs);
        return {sel[1:0], ofs[5:0]};
    endfunction

    function automatic logic [CFG-1:0] pack(int i, logic [OW-1:0] op);
        logic [CFG-1:0] v;
        int p;
        v = '0;
        v[OW-1:0] = op;
        p = OW;
        for (int k = 0; k < 3; k++)  begin v[p +: LW] = m_lv[i][k];    p += LW; end
        for (int k = 0; k < NA; k++) begin v[p +: AW] = m_base[i][k];  p += AW; end
        for (int k = 0; k < NL; k++) begin v[p +: CW] = m_bound[i][k]; p += CW; end
        for (int k = 0; k < NS; k++) begin v[p +: SW] = m_str[i][k];   p += SW; end
        return v;
    endfunction

    function automatic logic [CFG-1:0] cfg_of(int i);
        return eng_cfg[i*CFG +: CFG];
    endfunction

    task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(posedge clk);
        #1 bus_we = 0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 0;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_done(int i);
        @(negedge clk);
        eng_done[i] = 1;
        @(posedge clk);
        #1 eng_done[i] = 0;
    endtask

    function automatic bit tgt(int sel, int i);
        return sel == 3 || sel == i;
    endfunction

    task automatic set_base(int sel, int a, logic [DW-1:0] v);
        bus_write(A(sel, 8 + a), v);
        for (int i = 0; i < NI; i++) if (tgt(sel, i)) m_base[i][a] = v[AW-1:0];
    endtask
    task automatic set_bound(int sel, int l, logic [DW-1:0] v);
        bus_write(A(sel, 16 + l), v);
        for (int i = 0; i < NI; i++) if (tgt(sel, i)) m_bound[i][l] = v[CW-1:0];
    endtask
    task automatic set_str(int sel, int s, logic [DW-1:0] v);
        bus_write(A(sel, 32 + s), v);
        for (int i = 0; i < NI; i++) if (tgt(sel, i)) m_str[i][s] = v[SW-1:0];
    endtask
    task automatic set_lvl(int sel, logic [DW-1:0] v);
        bus_write(A(sel, 2), v);
        for (int i = 0; i < NI; i++)
            if (tgt(sel, i)) for (int k = 0; k < 3; k++) m_lv[i][k] = v[k*LW +: LW];
    endtask

    task automatic t_reset();
        logic [DW-1:0] r;
        chk("R1 ready", 256'(bus_ready), 256'd1);
        chk("R1 start", 256'(eng_start), 256'd0);
        chk("R1 cfg0", 256'(cfg_of(0)), 256'd0);
        chk("R1 cfg1", 256'(cfg_of(1)), 256'd0);
        bus_read(A(1, 0), r); chk("R1 status", 256'(r), 256'd0);
        bus_read(A(0, 17), r); chk("R1 bound", 256'(r), 256'd0);
    endtask

    task automatic t_fields();
        logic [DW-1:0] r;
        set_lvl(0, 32'hFFFF_FF1B);
        set_base(0, 0, 32'h1234_ABCD);
        set_base(0, 1, 32'h0000_2040);
        set_bound(0, 0, 32'hFFFF_F005);
        set_bound(0, 2, 32'h0000_0123);
        set_str(0, 0, 32'h0000_0004);
        set_str(0, 5, 32'hABCD_E987);
        bus_read(A(0, 2), r);  chk("R2 levels masked", 256'(r), 256'h1B);
        bus_read(A(0, 8), r);  chk("R2 base0 masked", 256'(r), 256'hABCD);
        bus_read(A(0, 16), r); chk("R2 bound0 masked", 256'(r), 256'h005);
        bus_read(A(0, 37), r); chk("R2 stride5 masked", 256'(r), 256'h987);
    endtask

    task automatic t_launch();
        logic [DW-1:0] r;
        logic [CFG-1:0] snap;
        bus_write(A(0, 1), 32'hFFFF_FF5A);
        m_opc[0] = 4'hA;
        snap = pack(0, 4'hA);
        chk("R3 start pulse", 256'(eng_start), 256'b01);
        chk("R3 snapshot", 256'(cfg_of(0)), 256'(snap));
        @(posedge clk); #1;
        chk("R3 single cycle", 256'(eng_start), 256'b00);
        bus_read(A(0, 1), r); chk("R3 opcode staged", 256'(r), 256'hA);
        bus_read(A(0, 0), r); chk("R5 busy", 256'(r), 256'd1);
        // R4: staging changes during execution
        set_base(0, 0, 32'h0000_7777);
        set_str(0, 2, 32'h0000_0333);
        chk("R4 cfg held", 256'(cfg_of(0)), 256'(snap));
        bus_read(A(0, 8), r); chk("R4 staging updated", 256'(r), 256'h7777);
        pulse_done(0);
        chk("R5 no start on done", 256'(eng_start), 256'd0);
        bus_read(A(0, 0), r); chk("R5 busy cleared", 256'(r), 256'd0);
        // R11: done while idle
        pulse_done(0);
        chk("R11 no start", 256'(eng_start), 256'd0);
        chk("R11 cfg unchanged", 256'(cfg_of(0)), 256'(snap));
        bus_read(A(0, 0), r); chk("R11 status idle", 256'(r), 256'd0);
    endtask

    task automatic t_queue();
        logic [DW-1:0] r;
        logic [CFG-1:0] s3, s4, s5;
        bus_write(A(0, 1), 32'h3);
        m_opc[0] = 4'h3; s3 = pack(0, 4'h3);
        chk("R3 launch 3", 256'(cfg_of(0)), 256'(s3));
        set_str(0, 4, 32'h0000_0055);
        bus_write(A(0, 1), 32'h4);
        m_opc[0] = 4'h4; s4 = pack(0, 4'h4);
        chk("R6 no start when queued", 256'(eng_start), 256'd0);
        chk("R6 cfg keeps running", 256'(cfg_of(0)), 256'(s3));
        bus_read(A(0, 0), r); chk("R6 busy+pending", 256'(r), 256'd3);
        set_bound(0, 1, 32'h0000_0099);
        @(negedge clk);
        bus_addr = A(0, 1); bus_wdata = 32'h5; bus_we = 1;
        #1 chk("R7 stalled", 256'(bus_ready), 256'd0);
        @(posedge clk);
        @(negedge clk);
        eng_done[0] = 1;
        #1 chk("R7 still stalled", 256'(bus_ready), 256'd0);
        @(posedge clk); #1;
        chk("R6 pending launched", 256'(eng_start), 256'b01);
        chk("R6 pending snapshot", 256'(cfg_of(0)), 256'(s4));
        chk("R7 ready after slot frees", 256'(bus_ready), 256'd1);
        m_opc[0] = 4'h5; s5 = pack(0, 4'h5);
        @(negedge clk);
        eng_done[0] = 0;
        @(posedge clk); #1;
        bus_we = 0;
        chk("R7 taken as pending", 256'(eng_start), 256'd0);
        bus_read(A(0, 0), r); chk("R7 pending again", 256'(r), 256'd3);
        pulse_done(0);
        chk("R6 second launch", 256'(eng_start), 256'b01);
        chk("R7 stalled write snapshot", 256'(cfg_of(0)), 256'(s5));
        pulse_done(0);
        bus_read(A(0, 0), r); chk("R5 idle after last", 256'(r), 256'd0);
    endtask

    task automatic t_bcast();
        logic [DW-1:0] r;
        logic [CFG-1:0] s0, s1;
        set_base(3, 1, 32'h0000_6161);
        set_bound(1, 0, 32'h0000_0042);
        bus_read(A(0, 9), r); chk("R8 bcast base inst0", 256'(r), 256'h6161);
        bus_read(A(1, 9), r); chk("R8 bcast base inst1", 256'(r), 256'h6161);
        bus_write(A(3, 1), 32'h7);
        m_opc[0] = 4'h7; m_opc[1] = 4'h7;
        s0 = pack(0, 4'h7); s1 = pack(1, 4'h7);
        chk("R8 both start", 256'(eng_start), 256'b11);
        chk("R8 inst0 cfg", 256'(cfg_of(0)), 256'(s0));
        chk("R8 inst1 cfg", 256'(cfg_of(1)), 256'(s1));
        pulse_done(1);
        bus_read(A(3, 0), r); chk("R9 bcast read is inst0", 256'(r), 256'd1);
        bus_read(A(1, 0), r); chk("R9 inst1 idle", 256'(r), 256'd0);
        bus_read(A(3, 16), r); chk("R9 bcast bound from inst0", 256'(r), 256'(m_bound[0][0]));
        pulse_done(0);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] r;
        bus_write(A(0, 5), 32'hDEAD_BEEF);
        bus_read(A(0, 5), r); chk("R10 hole reads zero", 256'(r), 256'd0);
        bus_write(A(2, 8), 32'h0000_1111);
        bus_read(A(0, 8), r); chk("R10 inst0 untouched", 256'(r), 256'(m_base[0][0]));
        bus_read(A(1, 8), r); chk("R10 inst1 untouched", 256'(r), 256'(m_base[1][0]));
        bus_read(A(2, 8), r); chk("R10 bad select reads zero", 256'(r), 256'd0);
        bus_write(A(2, 1), 32'h9);
        chk("R10 no launch", 256'(eng_start), 256'd0);
        bus_write(A(0, 0), 32'h3);
        bus_read(A(0, 0), r); chk("R10 status read-only", 256'(r), 256'd0);
    endtask

    initial begin
        for (int i = 0; i < NI; i++) begin
            m_opc[i] = '0;
            for (int k = 0; k < 3; k++)  m_lv[i][k] = '0;
            for (int k = 0; k < NA; k++) m_base[i][k] = '0;
            for (int k = 0; k < NL; k++) m_bound[i][k] = '0;
            for (int k = 0; k < NS; k++) m_str[i][k] = '0;
        end
        repeat (4) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_fields();
        t_launch();
        t_queue();
        t_bcast();
        t_unmapped();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule